// File: doc/BRIEF.md
# Comparator-Feedback Tracking Sigma-Delta ADC (Digital Part)

This block is the digital half of a low-cost tracking converter for slowly varying voltages. It holds its current estimate of the input in a saturating up/down counter. A first-order sigma-delta modulator turns that estimate into a one-bit stream. Off-chip, an RC low-pass filter smooths the stream into a voltage, and a comparator sets that voltage against the analog input. The comparator's single-bit answer comes back into the block and steers the counter up or down. The loop settles where the filtered stream matches the input, so the mean counter value becomes the measured level.

The counter is wider than the published result. Only its upper bits leave the block, so the dither in the low bits stays hidden. A parameter sets how often the counter may move, while the modulator runs on every clock. The block does not model the filter, the comparator or any other analog part.

Top module: `trk_sd_adc`

## Requirements
- R1: While `rst_n` is low, `result_o` and `bit_o` are 0 whatever `cmp_i` does, and asserting `rst_n` clears them without waiting for a clock edge.
- R2: `cmp_i` passes through two synchronizing flops. With `UPD_DIV`=1, a value applied before rising edge k changes the counter at edge k+2.
- R3: On an update cycle the counter rises by exactly one when the synchronized comparator bit is 1, and falls by exactly one when it is 0.
- R4: The counter saturates. It stays at 2^CNT_W-1 when told to rise, and stays at 0 when told to fall.
- R5: The counter may change only on update cycles. The first update cycle is the UPD_DIV-th rising edge after reset release, and the next ones follow every UPD_DIV edges. With UPD_DIV=1 every edge is an update cycle.
- R6: `bit_o` is the registered carry out of the CNT_W-bit phase accumulator plus the counter value. Over any 2^CNT_W consecutive clocks with a constant counter value c, it is 1 on exactly c clocks. Over the same span with the counter alternating between X and X+1, it is 1 on X or X+1 clocks.
- R7: The modulator advances on every clock whatever the setting of UPD_DIV.
- R8: `result_o` equals counter bits [CNT_W-1 : CNT_W-RES_W], which are its upper RES_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock, also the modulator rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cmp_i | input | 1 | Raw comparator bit, 1 when the input is above the filtered stream |
| bit_o | output | 1 | Modulator bitstream to the external RC filter |
| result_o | output | RES_W | Upper bits of the tracking counter |

## Verification
The two functions that can fall in the same cycle are a counter update and the saturation limit. The bench provokes this by holding the comparator steady long past full scale, then past zero, and by ending the vector table with a falling run that lands on zero. In every cycle a second event falls on the same clock: the modulator samples a counter that may just have moved. The comparator is toggled every cycle so the count alternates while the stream is counted over a full accumulator period. The results are judged cycle by cycle against a model built from the requirements, on two instances with different update rates, and by counting ones over complete 2^CNT_W windows.

// File: rtl/trk_sd_adc_pkg.sv
package trk_sd_adc_pkg;
  // Action taken by the tracking counter in one cycle
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/trk_sync2.sv
module trk_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  logic stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/trk_rate_div.sv
module trk_rate_div #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] ph_q;
  logic [DW-1:0] ph_d;
  logic          wrap;

  always_comb begin
    wrap = (ph_q == LAST);
    ph_d = wrap ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign tick_o = wrap;

  generate
    if (DIV > 1) begin : g_gap
      // R5
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/trk_updn_ctr.sv
module trk_updn_ctr
  import trk_sd_adc_pkg::*;
#(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         up_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = '1;

  cnt_op_e      op;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    op = OP_HOLD;
    if (en_i) begin
      if (up_i && (cnt_q != TOP))       op = OP_INC;
      else if (!up_i && (cnt_q != '0))  op = OP_DEC;
    end
    unique case (op)
      OP_INC:  cnt_d = cnt_q + 1'b1;
      OP_DEC:  cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && up_i && (cnt_q != TOP)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R3
  step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !up_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R4
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && up_i && (cnt_q == TOP)) |=> (cnt_q == TOP));
  // R4
  sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !up_i && (cnt_q == '0)) |=> (cnt_q == '0));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/trk_sd_mod.sv
module trk_sd_mod #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_i,
  output logic         bit_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] acc_q;
  logic [W-1:0] acc_d;
  logic         bit_q;
  logic         bit_d;
  logic [W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, din_i};
    acc_d = sum[W-1:0];
    bit_d = sum[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      bit_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      bit_q <= bit_d;
    end
  end

  assign bit_o = bit_q;

  // R6
  mod_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din_i == '0) |=> !bit_o);
  // R6
  mod_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((din_i == TOP) && (acc_q != '0)) |=> bit_o);
endmodule

// File: rtl/trk_sd_adc.sv
module trk_sd_adc #(
  parameter int CNT_W   = 14,
  parameter int RES_W   = 10,
  parameter int UPD_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_i,
  output logic             bit_o,
  output logic [RES_W-1:0] result_o
);
  localparam int LSB = CNT_W - RES_W;

  logic             cmp_s;
  logic             upd;
  logic [CNT_W-1:0] cnt;

  trk_sync2 u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  trk_rate_div #(.DIV(UPD_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (upd)
  );

  trk_updn_ctr #(.W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (upd),
    .up_i  (cmp_s),
    .cnt_o (cnt)
  );

  trk_sd_mod #(.W(CNT_W)) u_mod (
    .clk   (clk),
    .rst_n (rst_n),
    .din_i (cnt),
    .bit_o (bit_o)
  );

  assign result_o = cnt[CNT_W-1:LSB];

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |-> ((result_o == '0) && !bit_o));
  // R8
  res_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(result_o));
endmodule

// File: tb/test_trk_sd_adc.sv
module test_trk_sd_adc;
  localparam int CW   = 14;
  localparam int RW   = 10;
  localparam int SH   = CW - RW;
  localparam int CMAX = (1 << CW) - 1;
  localparam int RMAX = (1 << RW) - 1;
  localparam int WIN  = 1 << CW;
  localparam int DIVS [2] = '{1, 4};

  // stimulus table: mode 0 = hold low, 1 = hold high, 2 = toggle each cycle
  localparam int NV = 10;
  localparam int VMODE [NV] = '{1, 0, 1, 2, 0, 1, 2, 1, 0, 0};
  localparam int VLEN  [NV] = '{40, 9, 300, 25, 3, 177, 40, 12, 60, 600};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp = 1'b0;
  logic bit_a, bit_b;
  logic [RW-1:0] res_a, res_b;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  trk_sd_adc #(.CNT_W(CW), .RES_W(RW), .UPD_DIV(1)) i_trk_sd_adc (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .bit_o(bit_a), .result_o(res_a));

  trk_sd_adc #(.CNT_W(CW), .RES_W(RW), .UPD_DIV(4)) i_trk_sd_adc_slow (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .bit_o(bit_b), .result_o(res_b));

  // reference counter built from R2, R3, R4, R5
  int   m_cnt [2];
  int   m_ph  [2];
  logic m_s1, m_s2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= 1'b0;
      m_s2 <= 1'b0;
      for (int k = 0; k < 2; k++) begin
        m_cnt[k] <= 0;
        m_ph[k]  <= 0;
      end
    end else begin
      m_s1 <= cmp;
      m_s2 <= m_s1;
      for (int k = 0; k < 2; k++) begin
        if (m_ph[k] == DIVS[k] - 1) begin
          m_ph[k] <= 0;
          if (m_s2 && m_cnt[k] < CMAX)       m_cnt[k] <= m_cnt[k] + 1;
          else if (!m_s2 && m_cnt[k] > 0)    m_cnt[k] <= m_cnt[k] - 1;
        end else begin
          m_ph[k] <= m_ph[k] + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmp_models(input string tag);
    check(int'(res_a) == (m_cnt[0] >> SH), {tag, " div1"}, int'(res_a), m_cnt[0] >> SH);
    check(int'(res_b) == (m_cnt[1] >> SH), {tag, " div4"}, int'(res_b), m_cnt[1] >> SH);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(199000 * 20);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int ones_a;
    int ones_b;
    int xmin;

    // R1: reset holds outputs low even with the comparator high
    rst_n = 1'b0;
    cmp   = 1'b1;
    repeat (4) @(negedge clk);
    check(res_a == '0, "R1 result div1", int'(res_a), 0);
    check(res_b == '0, "R1 result div4", int'(res_b), 0);
    check(bit_a == 1'b0, "R1 bit div1", int'(bit_a), 0);
    check(bit_b == 1'b0, "R1 bit div4", int'(bit_b), 0);
    cmp   = 1'b0;
    rst_n = 1'b1;

    // table walk, compared every cycle (R2 R3 R5 R8)
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < VLEN[v]; c++) begin
        if (VMODE[v] == 2) cmp = ~cmp;
        else               cmp = (VMODE[v] == 1);
        cyc();
        cmp_models("R2 R3 R5 R8 table");
      end
    end
    check(m_cnt[0] == 0, "R4 table ends at floor", m_cnt[0], 0);

    // R4: drive past full scale on both instances
    cmp = 1'b1;
    repeat (65600) cyc();
    check(int'(res_a) == RMAX, "R4 top div1", int'(res_a), RMAX);
    check(int'(res_b) == RMAX, "R4 top div4", int'(res_b), RMAX);
    cmp_models("R4 R8 top");

    // R6 R7: full-period density at the top code on both rates
    ones_a = 0;
    ones_b = 0;
    for (int i = 0; i < WIN; i++) begin
      cyc();
      ones_a += int'(bit_a);
      ones_b += int'(bit_b);
    end
    check(ones_a == CMAX, "R6 density top div1", ones_a, CMAX);
    check(ones_b == CMAX, "R7 density top div4", ones_b, CMAX);

    // R4: drive past zero
    cmp = 1'b0;
    repeat (65600) cyc();
    check(res_a == '0, "R4 floor div1", int'(res_a), 0);
    check(res_b == '0, "R4 floor div4", int'(res_b), 0);
    ones_a = 0;
    for (int i = 0; i < 1024; i++) begin
      cyc();
      ones_a += int'(bit_a);
    end
    check(ones_a == 0, "R6 density zero div1", ones_a, 0);

    // R6: alternating count, density within one code of the mean
    cmp = 1'b1;
    repeat (5003) cyc();
    cmp_models("R3 R8 ramp");
    for (int i = 0; i < 8; i++) begin
      cmp = ~cmp;
      cyc();
    end
    xmin = CMAX;
    ones_a = 0;
    for (int i = 0; i < WIN; i++) begin
      cmp = ~cmp;
      cyc();
      ones_a += int'(bit_a);
      if (m_cnt[0] < xmin) xmin = m_cnt[0];
    end
    check((ones_a == xmin) || (ones_a == xmin + 1), "R6 density dither div1", ones_a, xmin);

    // R1: asynchronous clear between edges
    check(res_a != '0, "R1 precondition nonzero", int'(res_a), 1);
    #5;
    rst_n = 1'b0;
    #1;
    check(res_a == '0, "R1 async clear div1", int'(res_a), 0);
    check(bit_a == 1'b0, "R1 async clear bit", int'(bit_a), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule